// File: doc/BRIEF.md
# Powered-Device Port State Sequencer

This block tracks the line side of a powered device through its start-up steps. It does this using nothing but a stream of sampled port-voltage codes in millivolts. A converter outside the block supplies one code per cycle in which `sample_valid` is high. The block compares each code against fixed thresholds. The detection and lockout points have separate rising and falling values.

The sequencer presents the detection signature in the low voltage window. It then enables a classification current sink with a 2-bit class code. Finally it releases the undervoltage lockout that switches the power path on. A change of state needs a programmable number of consecutive qualifying samples, `QUAL_N`.

Only one classification event is honoured between resets. Once classification has ended, further mark or class steps are ignored until the port falls to the reset level.

Top module: `pd_port_seq`

## Requirements
- R1: While `rst_n` is low and just after it is released, `state_o` is 0 (reset), `sig_en`, `cls_en` and `pwr_rel` are 0, and `cls_code` is 0.
- R2: From reset, `QUAL_N` consecutive valid samples at or above `RST_MV` (2810) and within `DET_LO_MV`..`DET_HI_MV` (2700..10100) move the state to detect (1).
- R3: A state change is taken only on the `QUAL_N`-th consecutive valid sample that asks for the same change. A sample that asks for no change restarts the count. Cycles with `sample_valid` low neither count nor restart it.
- R4: `sig_en` is high only in detect, and only while the most recent valid sample lay inside the detection window. A single sample above 10100 drops it, and a sample back in the window raises it again.
- R5: From detect, `QUAL_N` samples above `CLS_ON_MV` (14500) enter classify (2). This raises `cls_en` and latches `class_sel` into `cls_code`. Code 0 asks the sink for 0-4 mA, 1 for 9-12 mA, 2 for 17-20 mA and 3 for 26-30 mA.
- R6: From classify, `QUAL_N` samples above `CLS_OFF_MV` (20500), or at or below 14500, end the event. The state moves to idle-high (3) and `cls_en` falls.
- R7: In idle-high, samples between 2810 and 37000 (mark or class steps) never re-enable `cls_en` and leave the state unchanged.
- R8: From idle-high, `QUAL_N` samples above `UVLO_R_MV` (37000) enter powered (4) and raise `pwr_rel`.
- R9: In powered, samples from 32000 to 37000 keep `pwr_rel` high. `QUAL_N` samples below `UVLO_F_MV` (32000) lock out again: the state goes to idle-high and `pwr_rel` falls.
- R10: In any state other than reset, `QUAL_N` samples below 2810 return to reset and clear `cls_code` to 0. This takes priority over every other exit.
- R11: The status encoding is: reset 0, detect 1, classify 2, idle-high 3, powered 4. The state changes only on the clock after a valid sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_valid | input | 1 | `sample_mv` carries a new port-voltage sample |
| sample_mv | input | 16 | Port voltage in millivolts |
| class_sel | input | 2 | Class code to present during classification |
| state_o | output | 3 | Current sequencer state |
| sig_en | output | 1 | Detection signature enable |
| cls_en | output | 1 | Classification current enable |
| cls_code | output | 2 | Class code to the current-sink driver |
| pwr_rel | output | 1 | Undervoltage lockout released, power path on |

## Verification
The assertions check the legal shape of the state graph on every cycle. They check that state changes and a rising signature follow a valid sample. They check that classify is entered only from detect and powered only from idle-high, and that the class code moves only on entry to classify or reset. Only the bench scenarios can show the actual thresholds and the consecutive-sample count. The same holds for the ignoring of a second class step and the hysteresis band around lockout. Those depend on particular voltage sequences.

// File: rtl/pd_port_seq_pkg.sv
package pd_port_seq_pkg;

    typedef enum logic [2:0] {
        ST_RESET    = 3'd0,
        ST_DETECT   = 3'd1,
        ST_CLASSIFY = 3'd2,
        ST_IDLE_HI  = 3'd3,
        ST_POWERED  = 3'd4
    } pd_state_e;

    typedef struct packed {
        logic low;      // below reset point
        logic in_win;   // inside detection window
        logic cls_on;   // above class-on point
        logic cls_off;  // above class-off point
        logic uv_rel;   // above rising lockout point
        logic uv_lock;  // below falling lockout point
    } pd_flags_t;

endpackage

// File: rtl/pd_seq_cmp.sv
module pd_seq_cmp
    import pd_port_seq_pkg::*;
#(
    parameter int MV_W       = 16,
    parameter int RST_MV     = 2810,
    parameter int DET_LO_MV  = 2700,
    parameter int DET_HI_MV  = 10100,
    parameter int CLS_ON_MV  = 14500,
    parameter int CLS_OFF_MV = 20500,
    parameter int UVLO_R_MV  = 37000,
    parameter int UVLO_F_MV  = 32000
) (
    input  logic [MV_W-1:0] mv,
    output pd_flags_t       flags
);
    localparam logic [MV_W-1:0] L_RST   = MV_W'(RST_MV);
    localparam logic [MV_W-1:0] L_DLO   = MV_W'(DET_LO_MV);
    localparam logic [MV_W-1:0] L_DHI   = MV_W'(DET_HI_MV);
    localparam logic [MV_W-1:0] L_CON   = MV_W'(CLS_ON_MV);
    localparam logic [MV_W-1:0] L_COFF  = MV_W'(CLS_OFF_MV);
    localparam logic [MV_W-1:0] L_UVR   = MV_W'(UVLO_R_MV);
    localparam logic [MV_W-1:0] L_UVF   = MV_W'(UVLO_F_MV);

    always_comb begin
        flags.low     = (mv < L_RST);
        flags.in_win  = (mv >= L_DLO) && (mv <= L_DHI);
        flags.cls_on  = (mv > L_CON);
        flags.cls_off = (mv > L_COFF);
        flags.uv_rel  = (mv > L_UVR);
        flags.uv_lock = (mv < L_UVF);
    end

endmodule

// File: rtl/pd_seq_qual.sv
module pd_seq_qual
    import pd_port_seq_pkg::*;
#(
    parameter int QUAL_N = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      valid,
    input  logic      want,
    input  pd_state_e cand,
    output logic      fire
);
    localparam int CW = (QUAL_N < 2) ? 1 : $clog2(QUAL_N + 1);
    localparam logic [CW-1:0] CNT_ONE = CW'(1);

    typedef struct packed {
        pd_state_e     pend;
        logic [CW-1:0] cnt;
    } qual_t;

    qual_t q_q, q_d;

    always_comb begin
        q_d  = q_q;
        fire = 1'b0;
        if (valid) begin
            if (!want) begin
                q_d.cnt = '0;
            end else if ((cand == q_q.pend) && (q_q.cnt != '0)) begin
                if (int'(q_q.cnt) + 1 >= QUAL_N) begin
                    fire    = 1'b1;
                    q_d.cnt = '0;
                end else begin
                    q_d.cnt = q_q.cnt + CNT_ONE;
                end
            end else begin
                q_d.pend = cand;
                if (QUAL_N <= 1) begin
                    fire    = 1'b1;
                    q_d.cnt = '0;
                end else begin
                    q_d.cnt = CNT_ONE;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= '{pend: ST_RESET, cnt: '0};
        end else begin
            q_q <= q_d;
        end
    end

endmodule

// File: rtl/pd_port_seq.sv
module pd_port_seq
    import pd_port_seq_pkg::*;
#(
    parameter int MV_W       = 16,
    parameter int QUAL_N     = 4,
    parameter int RST_MV     = 2810,
    parameter int DET_LO_MV  = 2700,
    parameter int DET_HI_MV  = 10100,
    parameter int CLS_ON_MV  = 14500,
    parameter int CLS_OFF_MV = 20500,
    parameter int UVLO_R_MV  = 37000,
    parameter int UVLO_F_MV  = 32000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sample_valid,
    input  logic [MV_W-1:0] sample_mv,
    input  logic [1:0]      class_sel,
    output logic [2:0]      state_o,
    output logic            sig_en,
    output logic            cls_en,
    output logic [1:0]      cls_code,
    output logic            pwr_rel
);
    typedef struct packed {
        pd_state_e  st;
        logic [1:0] code;
        logic       win;
    } seq_t;

    seq_t      r_q, r_d;
    pd_flags_t flags;
    pd_state_e cand;
    logic      want;
    logic      fire;

    pd_seq_cmp #(
        .MV_W       (MV_W),
        .RST_MV     (RST_MV),
        .DET_LO_MV  (DET_LO_MV),
        .DET_HI_MV  (DET_HI_MV),
        .CLS_ON_MV  (CLS_ON_MV),
        .CLS_OFF_MV (CLS_OFF_MV),
        .UVLO_R_MV  (UVLO_R_MV),
        .UVLO_F_MV  (UVLO_F_MV)
    ) cmp_i (
        .mv    (sample_mv),
        .flags (flags)
    );

    // Candidate next state for the current sample; reset has top priority.
    always_comb begin
        cand = r_q.st;
        unique case (r_q.st)
            ST_RESET:    if (flags.in_win && !flags.low) cand = ST_DETECT;
            ST_DETECT:   if (flags.low) cand = ST_RESET;
                         else if (flags.cls_on) cand = ST_CLASSIFY;
            ST_CLASSIFY: if (flags.low) cand = ST_RESET;
                         else if (flags.cls_off || !flags.cls_on) cand = ST_IDLE_HI;
            ST_IDLE_HI:  if (flags.low) cand = ST_RESET;
                         else if (flags.uv_rel) cand = ST_POWERED;
            ST_POWERED:  if (flags.low) cand = ST_RESET;
                         else if (flags.uv_lock) cand = ST_IDLE_HI;
            default:     cand = ST_RESET;
        endcase
        want = (cand != r_q.st);
    end

    pd_seq_qual #(
        .QUAL_N (QUAL_N)
    ) qual_i (
        .clk   (clk),
        .rst_n (rst_n),
        .valid (sample_valid),
        .want  (want),
        .cand  (cand),
        .fire  (fire)
    );

    always_comb begin
        r_d = r_q;
        if (sample_valid) begin
            r_d.win = flags.in_win;
        end
        if (fire) begin
            r_d.st = cand;
            if (cand == ST_CLASSIFY) begin
                r_d.code = class_sel;
            end else if (cand == ST_RESET) begin
                r_d.code = 2'd0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_RESET, code: 2'd0, win: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o  = r_q.st;
    assign sig_en   = (r_q.st == ST_DETECT) && r_q.win;
    assign cls_en   = (r_q.st == ST_CLASSIFY);
    assign cls_code = r_q.code;
    assign pwr_rel  = (r_q.st == ST_POWERED);

endmodule

// File: rtl/pd_port_seq_chk.sv
module pd_port_seq_chk
    import pd_port_seq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       sample_valid,
    input logic [2:0] state_o,
    input logic       sig_en,
    input logic [1:0] cls_code,
    input logic       pwr_rel
);
    // R11
    state_moves_on_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o != $past(state_o)) |-> $past(sample_valid));

    // R4
    sig_rises_on_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sig_en) |-> $past(sample_valid));

    // R5
    classify_from_detect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_o == ST_CLASSIFY) && ($past(state_o) != ST_CLASSIFY))
        |-> ($past(state_o) == ST_DETECT));

    // R8
    power_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_rel) |-> ($past(state_o) == ST_IDLE_HI));

    // R10
    code_moves_at_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cls_code) |-> ((state_o == ST_CLASSIFY) || (state_o == ST_RESET)));

    // R11
    state_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_o <= 3'd4);

endmodule

bind pd_port_seq pd_port_seq_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_valid (sample_valid),
    .state_o      (state_o),
    .sig_en       (sig_en),
    .cls_code     (cls_code),
    .pwr_rel      (pwr_rel)
);

// File: tb/pd_port_seq_tb_top.sv
module pd_port_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_valid = 1'b0;
    logic [15:0] sample_mv = '0;
    logic [1:0]  class_sel = 2'd2;
    logic [2:0]  state_o;
    logic        sig_en, cls_en, pwr_rel;
    logic [1:0]  cls_code;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    pd_port_seq dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_valid (sample_valid),
        .sample_mv    (sample_mv),
        .class_sel    (class_sel),
        .state_o      (state_o),
        .sig_en       (sig_en),
        .cls_en       (cls_en),
        .cls_code     (cls_code),
        .pwr_rel      (pwr_rel)
    );

    // mv, samples, state, sig, cls, code, pwr, requirement
    typedef struct packed {
        int         mv;
        int         n;
        logic [2:0] st;
        logic       sg;
        logic       cl;
        logic [1:0] cd;
        logic       pw;
        logic [7:0] rq;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{5000,  4, 3'd1, 1'b1, 1'b0, 2'd0, 1'b0, 8'd2},
        '{12000, 1, 3'd1, 1'b0, 1'b0, 2'd0, 1'b0, 8'd4},
        '{5000,  1, 3'd1, 1'b1, 1'b0, 2'd0, 1'b0, 8'd4},
        '{16000, 3, 3'd1, 1'b0, 1'b0, 2'd0, 1'b0, 8'd3},
        '{16000, 1, 3'd2, 1'b0, 1'b1, 2'd2, 1'b0, 8'd5},
        '{25000, 4, 3'd3, 1'b0, 1'b0, 2'd2, 1'b0, 8'd6},
        '{8000,  4, 3'd3, 1'b0, 1'b0, 2'd2, 1'b0, 8'd7},
        '{16000, 4, 3'd3, 1'b0, 1'b0, 2'd2, 1'b0, 8'd7},
        '{40000, 4, 3'd4, 1'b0, 1'b0, 2'd2, 1'b1, 8'd8},
        '{34000, 4, 3'd4, 1'b0, 1'b0, 2'd2, 1'b1, 8'd9},
        '{30000, 4, 3'd3, 1'b0, 1'b0, 2'd2, 1'b0, 8'd9},
        '{40000, 4, 3'd4, 1'b0, 1'b0, 2'd2, 1'b1, 8'd8},
        '{1000,  4, 3'd0, 1'b0, 1'b0, 2'd0, 1'b0, 8'd10}
    };

    task automatic chk(input string rq, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic chk_all(input string rq, input int st, input int sg,
                           input int cl, input int cd, input int pw);
        chk({rq, " state"}, int'(state_o), st);
        chk({rq, " sig_en"}, int'(sig_en), sg);
        chk({rq, " cls_en"}, int'(cls_en), cl);
        chk({rq, " cls_code"}, int'(cls_code), cd);
        chk({rq, " pwr_rel"}, int'(pwr_rel), pw);
    endtask

    task automatic drive(input int mv, input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            sample_mv    = 16'(mv);
            sample_valid = 1'b1;
            @(posedge clk);
        end
        @(negedge clk);
        sample_valid = 1'b0;
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(1);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(2);
        // R1 during reset
        chk_all("R1", 0, 0, 0, 0, 0);
        rst_n = 1'b1;
        idle(1);
        chk_all("R1", 0, 0, 0, 0, 0);

        // R2 R4 R5 R6 R7 R8 R9 R10 table walk
        for (int v = 0; v < NV; v++) begin
            drive(VECS[v].mv, VECS[v].n);
            chk_all($sformatf("R%0d", VECS[v].rq), int'(VECS[v].st), int'(VECS[v].sg),
                    int'(VECS[v].cl), int'(VECS[v].cd), int'(VECS[v].pw));
        end

        // R3: invalid cycles neither count nor restart the run
        drive(5000, 3);
        chk("R3 no early move", int'(state_o), 0);
        idle(5);
        drive(5000, 1);
        chk("R3 gap keeps count", int'(state_o), 1);

        // R3: a non-qualifying sample restarts the run
        do_reset();
        drive(5000, 3);
        drive(20000, 1);
        drive(5000, 3);
        chk("R3 broken run", int'(state_o), 0);
        drive(5000, 1);
        chk("R3 full run", int'(state_o), 1);

        // R2: just below the reset point, inside window, does not enter detect
        do_reset();
        drive(2750, 6);
        chk("R2 below reset point", int'(state_o), 0);

        // R5 class 3 then R10 from classify clears code
        class_sel = 2'd3;
        drive(6000, 4);
        drive(18000, 4);
        chk_all("R5", 2, 0, 1, 3, 0);
        drive(1500, 4);
        chk_all("R10", 0, 0, 0, 0, 0);

        // R6: falling back to a mark level also ends the event
        drive(6000, 4);
        drive(18000, 4);
        drive(9000, 4);
        chk_all("R6", 3, 0, 0, 3, 0);

        // R1: reset mid-sequence
        do_reset();
        chk_all("R1", 0, 0, 0, 0, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule